// File: doc/BRIEF.md
# Interval Tick Clock with Time-of-Year Counter

This block divides the system clock down to a fixed rate of 100 ticks per second. Each tick can raise an interrupt, advances a 32-bit time-of-year count, and every second tick also produces a poll strobe. Software controls it through a small control register and a read/write time-of-year register. Both are reached through plain write strobes, and their read data is always visible.

The time-of-year count starts out frozen. A battery-low flag is set at power-up and stops the counter from advancing. The flag clears only when software writes a nonzero time, or when the power-up preset input loads a seconds-since-start-of-year value. The preset value is converted to tick units, and a fixed offset of 0x10000000 is added to it. A reset clears the control register and any pending interrupt, and it restarts the prescaler from zero.

Top module: `rtc_tick_clock`

## Requirements
- R1: `tick` is a one-cycle pulse once every DIV = SYS_HZ/TICK_HZ system clocks. The first pulse comes in the DIV-th cycle after reset is released.
- R2: Control register bit 6 is the interrupt enable. It is readable and writable, and every other bit reads as zero. A write with bit 6 = 0 clears a pending interrupt, and this clear wins over a tick in the same cycle.
- R3: A tick while the enable is 1 sets `irq` on the next edge. `irq` stays high until a write clears it. A tick while the enable is 0 leaves `irq` low, and setting the enable later does not raise it.
- R4: When `batt_low` is 0, each tick increments the time-of-year count by one, wrapping from 0xFFFFFFFF to 0. When `batt_low` is 1, ticks leave the count unchanged.
- R5: A time-of-year write loads the written value. A nonzero value clears `batt_low`. A zero value leaves `batt_low` unchanged.
- R6: After reset, `batt_low` is 1, the count is 0, the enable is 0 and `irq` is 0.
- R7: `poll` fires together with every second tick after reset, that is on ticks 2, 4, 6 and so on.
- R8: `preset_load` sets the count to preset_secs*100 + 0x10000000 and clears `batt_low`. A time-of-year write in the same cycle takes priority.
- R9: Reset restarts the prescaler, so after a reset in the middle of a period the next tick is again DIV cycles away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Control register write strobe |
| csr_wdata | input | 16 | Control register write data |
| csr_rdata | output | 16 | Control register read data |
| toy_wr | input | 1 | Time-of-year write strobe |
| toy_wdata | input | 32 | Time-of-year write data |
| toy_rdata | output | 32 | Current time-of-year count |
| preset_load | input | 1 | Power-up preset load strobe |
| preset_secs | input | 25 | Seconds since start of year for the preset |
| tick | output | 1 | Tick pulse |
| poll | output | 1 | Half-rate poll pulse |
| irq | output | 1 | Clock interrupt request level |
| batt_low | output | 1 | Battery-low flag |

## Verification
A prescaler phase error shows at `tick` within one period, at most DIV cycles. An error in the poll phase shows at `poll` within two ticks. A wrong enable or interrupt state appears on `irq` on the edge after the next tick, or right after a clearing write. A corrupted count or battery flag appears on `toy_rdata` on the very next tick, because the count then advances when it should not, or fails to advance when it should. A reference model in the bench follows every one of these outputs cycle by cycle, so each divergence is reported in the cycle it occurs.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int CSR_W     = 16;
   localparam int IE_POS    = 6;
   localparam int TOY_W     = 32;
   localparam int SECS_W    = 25;
   localparam logic [TOY_W-1:0] TOY_OFFSET = 32'h1000_0000;

   typedef struct packed {
      logic ie;
   } ctl_state_t;

   typedef enum logic [1:0] {
      TOY_HOLD   = 2'd0,
      TOY_STEP   = 2'd1,
      TOY_LOAD   = 2'd2,
      TOY_PRESET = 2'd3
   } toy_op_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("rtc_prescaler: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R1
endmodule

// File: rtl/rtc_poll_div.sv
module rtc_poll_div #(
   parameter int POLL_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic poll
);
   generate
      if (POLL_DIV < 1) begin : g_bad_poll
         $error("rtc_poll_div: POLL_DIV must be at least 1");
      end else if (POLL_DIV == 1) begin : g_pass
         assign poll = tick;
      end else begin : g_count
         localparam int PW = $clog2(POLL_DIV);
         localparam logic [PW-1:0] PLAST = PW'(POLL_DIV - 1);
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ph_q <= '0;
            else if (tick)  ph_q <= (ph_q == PLAST) ? '0 : ph_q + 1'b1;
         end
         assign poll = tick && (ph_q == PLAST);
      end
   endgenerate

   AST_POLL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      poll |-> tick); // R7
endmodule

// File: rtl/rtc_ctl_csr.sv
module rtc_ctl_csr
   import rtc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             csr_wr,
   input  logic [CSR_W-1:0] csr_wdata,
   output logic [CSR_W-1:0] csr_rdata,
   output logic             irq
);
   ctl_state_t st_q;
   logic       irq_q;
   logic       wr_clear;

   assign wr_clear = csr_wr && !csr_wdata[IE_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q.ie <= 1'b0;
      else if (csr_wr) st_q.ie <= csr_wdata[IE_POS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                irq_q <= 1'b0;
      else if (wr_clear)         irq_q <= 1'b0;
      else if (tick && st_q.ie)  irq_q <= 1'b1;
   end

   always_comb begin
      csr_rdata         = '0;
      csr_rdata[IE_POS] = st_q.ie;
   end

   assign irq = irq_q;

   AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && !csr_wdata[IE_POS]) |=> !irq); // R2
   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !csr_wr) |=> irq); // R3
   AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !tick) |=> !irq); // R3
endmodule

// File: rtl/rtc_toy.sv
module rtc_toy
   import rtc_pkg::*;
#(
   parameter int TICK_HZ = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              toy_wr,
   input  logic [TOY_W-1:0]  toy_wdata,
   input  logic              preset_load,
   input  logic [SECS_W-1:0] preset_secs,
   output logic [TOY_W-1:0]  toy,
   output logic              batt_low
);
   localparam logic [TOY_W-1:0] SCALE = TOY_W'(TICK_HZ);

   logic [TOY_W-1:0] toy_q;
   logic             bl_q;
   logic [TOY_W-1:0] preset_val;
   toy_op_t          op;

   assign preset_val = (TOY_W'(preset_secs) * SCALE) + TOY_OFFSET;

   always_comb begin
      if (toy_wr)                op = TOY_LOAD;
      else if (preset_load)      op = TOY_PRESET;
      else if (tick && !bl_q)    op = TOY_STEP;
      else                       op = TOY_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         toy_q <= '0;
         bl_q  <= 1'b1;
      end else begin
         unique case (op)
            TOY_LOAD: begin
               toy_q <= toy_wdata;
               if (toy_wdata != '0) bl_q <= 1'b0;
            end
            TOY_PRESET: begin
               toy_q <= preset_val;
               bl_q  <= 1'b0;
            end
            TOY_STEP: toy_q <= toy_q + 1'b1;
            default:  toy_q <= toy_q;
         endcase
      end
   end

   assign toy      = toy_q;
   assign batt_low = bl_q;

   AST_TOY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bl_q && !toy_wr && !preset_load) |=> (toy_q == $past(toy_q))); // R4
   AST_ZERO_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (toy_wr && toy_wdata == '0) |=> (bl_q == $past(bl_q))); // R5
   AST_PRESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      preset_load |=> !bl_q); // R8
endmodule

// File: rtl/rtc_tick_clock.sv
module rtc_tick_clock
   import rtc_pkg::*;
#(
   parameter int SYS_HZ   = 100_000_000,
   parameter int TICK_HZ  = 100,
   parameter int POLL_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [CSR_W-1:0]  csr_wdata,
   output logic [CSR_W-1:0]  csr_rdata,
   input  logic              toy_wr,
   input  logic [TOY_W-1:0]  toy_wdata,
   output logic [TOY_W-1:0]  toy_rdata,
   input  logic              preset_load,
   input  logic [SECS_W-1:0] preset_secs,
   output logic              tick,
   output logic              poll,
   output logic              irq,
   output logic              batt_low
);
   localparam int DIV = SYS_HZ / TICK_HZ;

   generate
      if (TICK_HZ < 1 || (SYS_HZ % TICK_HZ) != 0) begin : g_bad_rate
         $error("rtc_tick_clock: SYS_HZ must be a multiple of TICK_HZ");
      end
   endgenerate

   logic tick_w;

   rtc_prescaler #(.DIV(DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick_w));

   rtc_poll_div #(.POLL_DIV(POLL_DIV)) u_poll (
      .clk(clk), .rst_n(rst_n), .tick(tick_w), .poll(poll));

   rtc_ctl_csr u_csr (
      .clk(clk), .rst_n(rst_n), .tick(tick_w), .csr_wr(csr_wr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq));

   rtc_toy #(.TICK_HZ(TICK_HZ)) u_toy (
      .clk(clk), .rst_n(rst_n), .tick(tick_w), .toy_wr(toy_wr),
      .toy_wdata(toy_wdata), .preset_load(preset_load),
      .preset_secs(preset_secs), .toy(toy_rdata), .batt_low(batt_low));

   assign tick = tick_w;
endmodule

// File: tb/rtc_tick_clock_tb.sv
module rtc_tick_clock_tb;
   localparam int SYS_HZ  = 1000;
   localparam int TICK_HZ = 100;
   localparam int DIV     = SYS_HZ / TICK_HZ;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [15:0] csr_wdata = '0;
   logic [15:0] csr_rdata;
   logic        toy_wr = 1'b0;
   logic [31:0] toy_wdata = '0;
   logic [31:0] toy_rdata;
   logic        preset_load = 1'b0;
   logic [24:0] preset_secs = '0;
   logic        tick, poll, irq, batt_low;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   rtc_tick_clock #(.SYS_HZ(SYS_HZ), .TICK_HZ(TICK_HZ), .POLL_DIV(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .toy_wr(toy_wr), .toy_wdata(toy_wdata),
      .toy_rdata(toy_rdata), .preset_load(preset_load),
      .preset_secs(preset_secs), .tick(tick), .poll(poll), .irq(irq),
      .batt_low(batt_low));

   // reference model built from the requirements
   int          m_cnt = 0;
   bit          m_phase = 0;
   bit          m_ie = 0, m_irq = 0, m_bl = 1;
   logic [31:0] m_toy = '0;
   bit          m_tick, m_poll;
   assign m_tick = rst_n && (m_cnt == DIV - 1);
   assign m_poll = m_tick && m_phase;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_phase = 0; m_ie = 0; m_irq = 0; m_bl = 1; m_toy = '0;
      end else begin
         bit t;
         t = m_tick;
         if (csr_wr && !csr_wdata[6]) m_irq = 0;
         else if (t && m_ie)          m_irq = 1;
         if (csr_wr) m_ie = csr_wdata[6];
         if (toy_wr) begin
            m_toy = toy_wdata;
            if (toy_wdata != 0) m_bl = 0;
         end else if (preset_load) begin
            m_toy = 32'(preset_secs) * 32'd100 + 32'h1000_0000;
            m_bl = 0;
         end else if (t && !m_bl) m_toy = m_toy + 1;
         if (t) begin m_cnt = 0; m_phase = !m_phase; end
         else m_cnt = m_cnt + 1;
      end
   end

   typedef struct {
      string       req;
      bit          is_toy;
      logic [31:0] exp;
   } item_t;
   item_t sb[$];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push(string req, bit is_toy, logic [31:0] exp);
      item_t it;
      it.req = req; it.is_toy = is_toy; it.exp = exp;
      sb.push_back(it);
   endtask

   // monitor: samples 2 ns after each rising edge
   always begin
      @(posedge clk); #2;
      check("R1 R9 tick", 32'(tick), 32'(m_tick));
      check("R7 poll", 32'(poll), 32'(m_poll));
      check("R3 irq", 32'(irq), 32'(m_irq));
      check("R4 toy", toy_rdata, m_toy);
      check("R5 batt_low", 32'(batt_low), 32'(m_bl));
      while (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         check(it.req, it.is_toy ? toy_rdata : 32'(csr_rdata), it.exp);
      end
   end

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic csr_write(logic [15:0] d, logic [15:0] exp_rd);
      @(negedge clk); csr_wr = 1; csr_wdata = d;
      push("R2 csr readback", 0, 32'(exp_rd));
      @(negedge clk); csr_wr = 0;
   endtask

   task automatic toy_write(logic [31:0] d);
      @(negedge clk); toy_wr = 1; toy_wdata = d;
      push("R5 toy load", 1, d);
      @(negedge clk); toy_wr = 0;
   endtask

   task automatic do_reset(int hold);
      @(negedge clk); rst_n = 0;
      cycles(hold);
      rst_n = 1;
   endtask

   initial begin
      cycles(3);
      rst_n = 1;
      push("R6 reset toy", 1, 32'h0);
      push("R6 reset csr", 0, 32'h0);
      // frozen count while battery low
      cycles(3 * DIV);
      push("R4 frozen", 1, 32'h0);
      toy_write(32'h0);                // R5 zero write keeps flag
      cycles(2 * DIV);
      toy_write(32'h0000_0100);        // R5 nonzero clears flag
      cycles(3 * DIV + 2);
      // enable and interrupt
      csr_write(16'h0040, 16'h0040);   // R2
      csr_write(16'hFFFF, 16'h0040);   // R2 only bit 6 implemented
      cycles(3 * DIV);                 // R3 irq held
      csr_write(16'h0000, 16'h0000);   // R2 clear
      cycles(2 * DIV + 1);             // R3 ticks with IE=0
      csr_write(16'h0040, 16'h0040);   // R3 no late raise
      cycles(2);
      // clear coinciding with a tick: clear wins (R2)
      do @(negedge clk); while (!m_tick);
      csr_wr = 1; csr_wdata = 16'h0000;
      @(negedge clk); csr_wr = 0;
      cycles(DIV);
      // wraparound (R4)
      toy_write(32'hFFFF_FFFE);
      cycles(3 * DIV);
      // mid-period reset (R9) then preset (R8)
      cycles(DIV / 2);
      do_reset(2);
      cycles(DIV + 3);
      @(negedge clk); preset_load = 1; preset_secs = 25'd12345;
      push("R8 preset value", 1, 32'd1234500 + 32'h1000_0000);
      @(negedge clk); preset_load = 0;
      cycles(2 * DIV);
      // write beats preset in the same cycle (R8)
      @(negedge clk); preset_load = 1; preset_secs = 25'd7;
      toy_wr = 1; toy_wdata = 32'h0000_1234;
      push("R8 write priority", 1, 32'h0000_1234);
      @(negedge clk); preset_load = 0; toy_wr = 0;
      cycles(4 * DIV);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule